// File: doc/BRIEF.md
# Committed-Store Buffer with Load Forwarding

This block holds stores that have already committed, keeps them in program order, and writes them to an external memory system over several parallel issue lanes. Each slot of a circular queue carries an address, a byte count, little-endian data, and a per-slot progress state. A store is accepted at the back of the queue only while space remains. It is offered to memory oldest-first. It is marked done when the memory reports completion, and it leaves the queue from the front.

A load that is about to go to memory first probes the buffer. The probe compares the load's byte range against every live store. The youngest store that touches the load decides the answer. If that store holds every byte of the load, its bytes are returned, realigned so that the load's first byte sits in byte lane 0. If it holds only some of the bytes, the answer is "partial" and the load must wait.

Ordering markers (barriers) can also be queued. A barrier never goes to memory and is not counted as pending work. It blocks every younger store until it reaches the front of the queue and is removed.

Top module: `store_buf`

## Requirements
- R1: After reset the buffer is empty: `drained`=1, `ins_ok`=1, `unissued_cnt`=0 and no issue lane is valid.
- R2: An insert is taken at the back only when `ins_ok`=1. `ins_ok` is 0 while all SLOTS slots are occupied, and an insert attempted then has no effect: the count and lookups are unchanged. Slots are assigned circularly, starting at slot 0 after reset.
- R3: Pending stores are offered oldest-first on at most ISSUE_W lanes per cycle. Lane 0 carries the oldest store, the lanes used form a contiguous group from lane 0, and `iss_slot` gives each lane's slot index.
- R4: `unissued_cnt` rises by one for each store inserted and falls by one for each lane accepted. Barrier inserts never change it.
- R5: The lookup class `ld_cover` is 2 (full) when the store range [addr, addr+size-1] contains the whole load range, 1 (partial) when the two ranges overlap otherwise, and 0 (none) when they are disjoint.
- R6: On full coverage, `ld_slot` names the store's slot and `ld_data` is the store data shifted right by 8×(load address − store address), so byte lane 0 holds the byte at the load address. On any other class `ld_data` is 0.
- R7: When several live stores overlap the load, the youngest one alone decides the class, the slot and the data.
- R8: A lane is accepted only when its `iss_ready` bit is 1 and every lower valid lane was accepted. The first refused store enters a retry wait. While it waits, nothing is offered. A `mem_retry` pulse makes it eligible again, and it is offered in the following cycle.
- R9: A completion (`cmp_valid`, `cmp_slot`) marks an issued store done, and done entries leave strictly from the front, one per cycle. A completion naming a slot that has not been issued is ignored.
- R10: A barrier is never offered to memory. No store younger than a barrier is offered until the barrier has left the front of the queue, which happens once every older entry has left.
- R11: `drained` is 1 exactly when no entry of any kind, stores or barriers, remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_barrier | input | 1 | Insert is a barrier marker rather than a store |
| ins_addr | input | AW | Store byte address |
| ins_size | input | SZW | Store byte count (1..BYTES) |
| ins_data | input | DW | Store data, little-endian from the address |
| ins_ok | output | 1 | A slot is free for an insert |
| iss_valid | output | ISSUE_W | Per-lane memory request valid |
| iss_addr | output | ISSUE_W*AW | Per-lane address |
| iss_size | output | ISSUE_W*SZW | Per-lane byte count |
| iss_data | output | ISSUE_W*DW | Per-lane data |
| iss_slot | output | ISSUE_W*IW | Per-lane slot index, used as completion tag |
| iss_ready | input | ISSUE_W | Per-lane memory acceptance |
| mem_retry | input | 1 | Pulse: a refused store may be offered again |
| cmp_valid | input | 1 | Memory write completed |
| cmp_slot | input | IW | Slot of the completed write |
| ld_addr | input | AW | Load byte address for lookup |
| ld_size | input | SZW | Load byte count |
| ld_cover | output | 2 | 0 none, 1 partial, 2 full |
| ld_slot | output | IW | Slot of the deciding store |
| ld_data | output | DW | Forwarded bytes, zero unless full |
| unissued_cnt | output | CW | Stores not yet accepted by memory |
| drained | output | 1 | Buffer holds no entries |

## Verification
On every cycle, the assertions check the following: occupancy and pending-store bounds, and that the issue lanes stay contiguous and never carry a barrier. They also check that a refused lane goes quiet in the next cycle, that no lookup other than a full hit returns data, and that the pending count never drops faster than the lane count allows. Only the bench scenarios can show the rest. This covers the three coverage classes against real byte ranges, the shifted data, and the youngest-store choice. It also covers the partial-acceptance and retry sequences, the in-order departure after out-of-order completions, and a barrier holding back a younger store.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    typedef enum logic [1:0] {
        COV_NONE = 2'd0,
        COV_PART = 2'd1,
        COV_FULL = 2'd2
    } cov_e;

    typedef enum logic [2:0] {
        SL_EMPTY  = 3'd0,
        SL_PEND   = 3'd1,
        SL_RETRY  = 3'd2,
        SL_ISSUED = 3'd3,
        SL_DONE   = 3'd4
    } slot_e;
endpackage

// File: rtl/sb_range_cmp.sv
`timescale 1ns/1ps
// Classifies how one store byte range relates to one load byte range.
module sb_range_cmp
    import sb_pkg::*;
#(
    parameter int AW  = 16,
    parameter int SZW = 3
) (
    input  logic [AW-1:0]  st_addr,
    input  logic [SZW-1:0] st_size,
    input  logic [AW-1:0]  ld_addr,
    input  logic [SZW-1:0] ld_size,
    output cov_e           cov
);
    localparam int PADW = AW + 1 - SZW;

    logic [AW:0] s_lo, s_end, l_lo, l_end;
    logic        full, overlap;

    always_comb begin
        s_lo    = {1'b0, st_addr};
        l_lo    = {1'b0, ld_addr};
        s_end   = s_lo + {{PADW{1'b0}}, st_size};
        l_end   = l_lo + {{PADW{1'b0}}, ld_size};
        full    = (s_lo <= l_lo) && (l_end <= s_end);
        overlap = (s_lo < l_end) && (l_lo < s_end);
        if (full)         cov = COV_FULL;
        else if (overlap) cov = COV_PART;
        else              cov = COV_NONE;
    end
endmodule

// File: rtl/sb_issue_sel.sv
`timescale 1ns/1ps
// Walks the queue from the front and picks up to ISSUE_W pending stores.
module sb_issue_sel
    import sb_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int ISSUE_W = 2,
    localparam int IW     = $clog2(SLOTS)
) (
    input  logic [SLOTS*3-1:0]    st_flat,
    input  logic [SLOTS-1:0]      bar_mask,
    input  logic [IW-1:0]         head,
    output logic [ISSUE_W-1:0]    lane_vld,
    output logic [ISSUE_W*IW-1:0] lane_slot
);
    slot_e st_arr [SLOTS];

    always_comb begin
        for (int s = 0; s < SLOTS; s++) st_arr[s] = slot_e'(st_flat[s*3 +: 3]);
    end

    always_comb begin
        logic          stop;
        int            n;
        logic [IW-1:0] idx;
        lane_vld  = '0;
        lane_slot = '0;
        stop      = 1'b0;
        n         = 0;
        idx       = '0;
        for (int k = 0; k < SLOTS; k++) begin
            idx = head + IW'(k);
            if (!stop) begin
                // end of queue, a barrier or a store awaiting retry halts in-order issue
                if (st_arr[idx] == SL_EMPTY || bar_mask[idx] || st_arr[idx] == SL_RETRY) begin
                    stop = 1'b1;
                end else if (st_arr[idx] == SL_PEND) begin
                    if (n < ISSUE_W) begin
                        for (int l = 0; l < ISSUE_W; l++) begin
                            if (n == l) begin
                                lane_vld[l]             = 1'b1;
                                lane_slot[l*IW +: IW]   = idx;
                            end
                        end
                        n = n + 1;
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sb_fwd_pick.sv
`timescale 1ns/1ps
// Chooses the youngest live store that touches the load.
module sb_fwd_pick
    import sb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic [SLOTS*2-1:0] cov_flat,
    input  logic [SLOTS-1:0]   live,
    input  logic [IW-1:0]      head,
    output cov_e               cov,
    output logic [IW-1:0]      slot
);
    cov_e cov_arr [SLOTS];

    always_comb begin
        for (int s = 0; s < SLOTS; s++) cov_arr[s] = cov_e'(cov_flat[s*2 +: 2]);
    end

    always_comb begin
        logic [IW-1:0] idx;
        cov  = COV_NONE;
        slot = '0;
        idx  = '0;
        // oldest to youngest; a later hit overrides, so the youngest wins
        for (int k = 0; k < SLOTS; k++) begin
            idx = head + IW'(k);
            if (live[idx] && cov_arr[idx] != COV_NONE) begin
                cov  = cov_arr[idx];
                slot = idx;
            end
        end
    end
endmodule

// File: rtl/store_buf.sv
`timescale 1ns/1ps
module store_buf
    import sb_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int AW      = 16,
    parameter int BYTES   = 4,
    parameter int ISSUE_W = 2,
    localparam int IW     = $clog2(SLOTS),
    localparam int SZW    = $clog2(BYTES) + 1,
    localparam int DW     = BYTES * 8,
    localparam int CW     = $clog2(SLOTS + 1),
    localparam int OW     = $clog2(BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ins_valid,
    input  logic                   ins_barrier,
    input  logic [AW-1:0]          ins_addr,
    input  logic [SZW-1:0]         ins_size,
    input  logic [DW-1:0]          ins_data,
    output logic                   ins_ok,
    output logic [ISSUE_W-1:0]     iss_valid,
    output logic [ISSUE_W*AW-1:0]  iss_addr,
    output logic [ISSUE_W*SZW-1:0] iss_size,
    output logic [ISSUE_W*DW-1:0]  iss_data,
    output logic [ISSUE_W*IW-1:0]  iss_slot,
    input  logic [ISSUE_W-1:0]     iss_ready,
    input  logic                   mem_retry,
    input  logic                   cmp_valid,
    input  logic [IW-1:0]          cmp_slot,
    input  logic [AW-1:0]          ld_addr,
    input  logic [SZW-1:0]         ld_size,
    output logic [1:0]             ld_cover,
    output logic [IW-1:0]          ld_slot,
    output logic [DW-1:0]          ld_data,
    output logic [CW-1:0]          unissued_cnt,
    output logic                   drained
);
    typedef struct packed {
        slot_e          st;
        logic           bar;
        logic [AW-1:0]  addr;
        logic [SZW-1:0] size;
        logic [DW-1:0]  data;
    } ent_t;

    typedef struct packed {
        ent_t [SLOTS-1:0] ent;
        logic [IW-1:0]    head;
        logic [IW-1:0]    tail;
        logic [CW-1:0]    count;
        logic [CW-1:0]    unissued;
    } sb_t;

    sb_t q, d;

    logic [SLOTS*3-1:0]    st_flat;
    logic [SLOTS-1:0]      bar_mask;
    logic [SLOTS-1:0]      live;
    logic [SLOTS*2-1:0]    cov_flat;
    logic [ISSUE_W-1:0]    lane_vld;
    logic [ISSUE_W*IW-1:0] lane_slot;
    cov_e                  pk_cov;
    logic [IW-1:0]         pk_slot;
    logic [OW-1:0]         fwd_off;

    assign ins_ok       = (q.count != CW'(SLOTS));
    assign drained      = (q.count == '0);
    assign unissued_cnt = q.unissued;

    // ---------------- per-slot views and range compare ----------------
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        cov_e cov_s;
        assign st_flat[s*3 +: 3] = q.ent[s].st;
        assign bar_mask[s]       = q.ent[s].bar;
        assign live[s]           = (q.ent[s].st != SL_EMPTY) && !q.ent[s].bar;
        sb_range_cmp #(.AW(AW), .SZW(SZW)) u_cmp (
            .st_addr (q.ent[s].addr),
            .st_size (q.ent[s].size),
            .ld_addr (ld_addr),
            .ld_size (ld_size),
            .cov     (cov_s)
        );
        assign cov_flat[s*2 +: 2] = cov_s;
    end

    sb_fwd_pick #(.SLOTS(SLOTS)) u_pick (
        .cov_flat (cov_flat),
        .live     (live),
        .head     (q.head),
        .cov      (pk_cov),
        .slot     (pk_slot)
    );

    assign fwd_off  = ld_addr[OW-1:0] - q.ent[pk_slot].addr[OW-1:0];
    assign ld_cover = pk_cov;
    assign ld_slot  = pk_slot;
    assign ld_data  = (pk_cov == COV_FULL) ? (q.ent[pk_slot].data >> {fwd_off, 3'b000}) : '0;

    // ---------------- issue lanes ----------------
    sb_issue_sel #(.SLOTS(SLOTS), .ISSUE_W(ISSUE_W)) u_sel (
        .st_flat   (st_flat),
        .bar_mask  (bar_mask),
        .head      (q.head),
        .lane_vld  (lane_vld),
        .lane_slot (lane_slot)
    );

    assign iss_valid = lane_vld;
    assign iss_slot  = lane_slot;

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
        logic [IW-1:0] ls;
        assign ls                        = lane_slot[l*IW +: IW];
        assign iss_addr[l*AW +: AW]      = q.ent[ls].addr;
        assign iss_size[l*SZW +: SZW]    = q.ent[ls].size;
        assign iss_data[l*DW +: DW]      = q.ent[ls].data;
    end

    // ---------------- next state ----------------
    always_comb begin
        logic          run;
        logic [CW-1:0] acc_n;
        logic          do_ret;
        logic          do_ins;
        d      = q;
        run    = 1'b1;
        acc_n  = '0;
        do_ret = 1'b0;
        do_ins = ins_valid && ins_ok;

        // completion only counts for a store actually in memory
        if (cmp_valid && q.ent[cmp_slot].st == SL_ISSUED) d.ent[cmp_slot].st = SL_DONE;

        // a retry pulse releases the waiting store
        for (int s = 0; s < SLOTS; s++) begin
            if (mem_retry && q.ent[s].st == SL_RETRY) d.ent[s].st = SL_PEND;
        end

        // memory takes a prefix of the offered lanes
        for (int l = 0; l < ISSUE_W; l++) begin
            if (lane_vld[l] && run) begin
                if (iss_ready[l]) begin
                    d.ent[lane_slot[l*IW +: IW]].st = SL_ISSUED;
                    acc_n = acc_n + 1'b1;
                end else begin
                    d.ent[lane_slot[l*IW +: IW]].st = SL_RETRY;
                    run = 1'b0;
                end
            end
        end

        // front entry leaves once done (barriers enter already done)
        if (q.count != '0 && q.ent[q.head].st == SL_DONE) begin
            d.ent[q.head].st = SL_EMPTY;
            d.head           = q.head + 1'b1;
            do_ret           = 1'b1;
        end

        if (do_ins) begin
            d.ent[q.tail].st   = ins_barrier ? SL_DONE : SL_PEND;
            d.ent[q.tail].bar  = ins_barrier;
            d.ent[q.tail].addr = ins_addr;
            d.ent[q.tail].size = ins_size;
            d.ent[q.tail].data = ins_data;
            d.tail             = q.tail + 1'b1;
        end

        d.count    = q.count + CW'(do_ins) - CW'(do_ret);
        d.unissued = q.unissued + CW'(do_ins && !ins_barrier) - acc_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ---------------- assertions ----------------
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(SLOTS));

    assert_unissued_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.unissued <= q.count);

    assert_unissued_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(unissued_cnt) + ISSUE_W >= int'($past(unissued_cnt)));

    assert_drained_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (iss_valid == '0));

    assert_fwd_full_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cover != COV_FULL) |-> (ld_data == '0));

    assert_refused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[0] && !iss_ready[0]) |=> !iss_valid[0]);

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane_chk
        assert_no_barrier_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[l] |-> !q.ent[iss_slot[l*IW +: IW]].bar);
        if (l > 0) begin : g_contig
            assert_lane_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[l] |-> iss_valid[l-1]);
        end
    end
endmodule

// File: tb/sim_store_buf.sv
`timescale 1ns/1ps
module sim_store_buf;
    localparam int SLOTS = 4, AW = 16, BYTES = 4, ISSUE_W = 2;
    localparam int IW = 2, SZW = 3, DW = 32, CW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic ins_valid, ins_barrier;
    logic [AW-1:0] ins_addr;
    logic [SZW-1:0] ins_size;
    logic [DW-1:0] ins_data;
    logic ins_ok;
    logic [ISSUE_W-1:0] iss_valid, iss_ready;
    logic [ISSUE_W*AW-1:0] iss_addr;
    logic [ISSUE_W*SZW-1:0] iss_size;
    logic [ISSUE_W*DW-1:0] iss_data;
    logic [ISSUE_W*IW-1:0] iss_slot;
    logic mem_retry, cmp_valid;
    logic [IW-1:0] cmp_slot;
    logic [AW-1:0] ld_addr;
    logic [SZW-1:0] ld_size;
    logic [1:0] ld_cover;
    logic [IW-1:0] ld_slot;
    logic [DW-1:0] ld_data;
    logic [CW-1:0] unissued_cnt;
    logic drained;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    store_buf #(.SLOTS(SLOTS), .AW(AW), .BYTES(BYTES), .ISSUE_W(ISSUE_W)) u0 (.*);

    typedef struct packed {
        logic [15:0] a;
        logic [2:0]  sz;
        logic [1:0]  cov;
        logic [31:0] dat;
    } vec_t;

    // store at 0x100, 4 bytes, data 0x44332211
    localparam vec_t VEC [9] = '{
        '{16'h0100, 3'd4, 2'd2, 32'h44332211},
        '{16'h0101, 3'd2, 2'd2, 32'h00443322},
        '{16'h0102, 3'd2, 2'd2, 32'h00004433},
        '{16'h0103, 3'd1, 2'd2, 32'h00000044},
        '{16'h00FE, 3'd4, 2'd1, 32'h00000000},
        '{16'h0103, 3'd2, 2'd1, 32'h00000000},
        '{16'h0104, 3'd1, 2'd0, 32'h00000000},
        '{16'h00FC, 3'd4, 2'd0, 32'h00000000},
        '{16'h00FF, 3'd1, 2'd0, 32'h00000000}
    };

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ins_valid = 1'b0; ins_barrier = 1'b0; ins_addr = '0; ins_size = '0;
        ins_data = '0; iss_ready = '0; mem_retry = 1'b0; cmp_valid = 1'b0; cmp_slot = '0;
        ld_addr = '0; ld_size = 3'd1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic put_store(input logic [15:0] a, input logic [2:0] sz, input logic [31:0] dt);
        ins_valid = 1'b1; ins_barrier = 1'b0; ins_addr = a; ins_size = sz; ins_data = dt;
        tick();
        ins_valid = 1'b0;
    endtask

    task automatic put_bar();
        ins_valid = 1'b1; ins_barrier = 1'b1; ins_addr = '0; ins_size = 3'd1; ins_data = '0;
        tick();
        ins_valid = 1'b0; ins_barrier = 1'b0;
    endtask

    task automatic complete(input logic [1:0] s);
        cmp_valid = 1'b1; cmp_slot = s;
        tick();
        cmp_valid = 1'b0;
    endtask

    task automatic pulse_retry();
        mem_retry = 1'b1;
        tick();
        mem_retry = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [2:0] sz);
        ld_addr = a; ld_size = sz;
        #1;
    endtask

    initial begin
        // ---- R1 / R11 reset state
        do_reset();
        chk("R1", "drained", drained, 1);
        chk("R1", "ins_ok", ins_ok, 1);
        chk("R1", "unissued", unissued_cnt, 0);
        chk("R1", "iss_valid", iss_valid, 0);
        chk("R11", "drained empty", drained, 1);

        // ---- R5 / R6 vector table
        iss_ready = 2'b11;
        put_store(16'h0100, 3'd4, 32'h44332211);
        for (int i = 0; i < 9; i++) begin
            probe(VEC[i].a, VEC[i].sz);
            chk("R5", $sformatf("cover vec%0d", i), ld_cover, VEC[i].cov);
            chk("R6", $sformatf("data vec%0d", i), ld_data, VEC[i].dat);
            if (VEC[i].cov == 2'd2) chk("R6", $sformatf("slot vec%0d", i), ld_slot, 0);
        end
        tick();
        complete(2'd0);
        chk("R11", "done entry still held", drained, 0);
        tick();
        chk("R9", "completed store left", drained, 1);

        // ---- R7 youngest store decides
        do_reset();
        iss_ready = 2'b11;
        put_store(16'h0200, 3'd4, 32'hAAAAAAAA);
        put_store(16'h0202, 3'd2, 32'h0000BBCC);
        probe(16'h0202, 3'd2);
        chk("R7", "young full cover", ld_cover, 2);
        chk("R7", "young full slot", ld_slot, 1);
        chk("R7", "young full data", ld_data, 32'h0000BBCC);
        probe(16'h0200, 3'd4);
        chk("R7", "young partial cover", ld_cover, 1);
        chk("R6", "partial gives zero", ld_data, 0);
        probe(16'h0200, 3'd2);
        chk("R7", "older full cover", ld_cover, 2);
        chk("R7", "older full slot", ld_slot, 0);
        chk("R7", "older full data", ld_data, 32'hAAAAAAAA);

        // ---- R3 / R4 / R8 / R9 issue order, cap, refusal and retry
        do_reset();
        iss_ready = 2'b00;
        put_store(16'h0300, 3'd4, 32'h11111111);
        chk("R4", "count after one", unissued_cnt, 1);
        chk("R3", "single lane", iss_valid, 2'b01);
        chk("R3", "lane0 addr", iss_addr[15:0], 16'h0300);
        put_store(16'h0304, 3'd4, 32'h22222222);
        chk("R8", "waiting blocks issue", iss_valid, 0);
        chk("R4", "count after two", unissued_cnt, 2);
        put_store(16'h0308, 3'd4, 32'h33333333);
        chk("R4", "count after three", unissued_cnt, 3);
        complete(2'd0);
        chk("R8", "no reoffer without pulse", iss_valid, 0);
        pulse_retry();
        chk("R8", "reoffer after pulse", iss_valid, 2'b11);
        chk("R3", "cap two oldest slots", iss_slot, 4'b0100);
        chk("R9", "early completion ignored", iss_slot[1:0], 0);
        iss_ready = 2'b10;
        tick();
        chk("R8", "lane1 alone not taken", unissued_cnt, 3);
        chk("R8", "quiet after refusal", iss_valid, 0);
        pulse_retry();
        iss_ready = 2'b01;
        tick();
        chk("R8", "prefix taken", unissued_cnt, 2);
        chk("R8", "quiet after second refusal", iss_valid, 0);
        pulse_retry();
        chk("R3", "next two offered", iss_valid, 2'b11);
        chk("R3", "next two slots", iss_slot, 4'b1001);
        iss_ready = 2'b11;
        tick();
        chk("R4", "all accepted", unissued_cnt, 0);
        chk("R3", "nothing left to offer", iss_valid, 0);
        complete(2'd2);
        complete(2'd1);
        tick();
        chk("R9", "front not done holds", drained, 0);
        complete(2'd0);
        tick();
        tick();
        chk("R9", "one per cycle", drained, 0);
        tick();
        chk("R9", "all left in order", drained, 1);

        // ---- R2 full buffer
        do_reset();
        iss_ready = 2'b11;
        put_store(16'h0400, 3'd4, 32'h01010101);
        put_store(16'h0404, 3'd4, 32'h02020202);
        put_store(16'h0408, 3'd4, 32'h03030303);
        chk("R2", "room left", ins_ok, 1);
        put_store(16'h040C, 3'd4, 32'h04040404);
        chk("R2", "full blocks", ins_ok, 0);
        tick();
        chk("R4", "all issued", unissued_cnt, 0);
        put_store(16'h0900, 3'd4, 32'h09090909);
        chk("R2", "ignored insert count", unissued_cnt, 0);
        probe(16'h0900, 3'd4);
        chk("R2", "ignored insert lookup", ld_cover, 0);
        chk("R2", "still full", ins_ok, 0);

        // ---- R10 barrier
        do_reset();
        iss_ready = 2'b11;
        put_store(16'h0500, 3'd4, 32'h55555555);
        put_bar();
        chk("R4", "barrier not counted", unissued_cnt, 0);
        chk("R11", "barrier occupies", drained, 0);
        put_store(16'h0504, 3'd4, 32'h66666666);
        chk("R4", "store after barrier counted", unissued_cnt, 1);
        chk("R10", "younger held", iss_valid, 0);
        tick();
        chk("R10", "younger still held", iss_valid, 0);
        complete(2'd0);
        chk("R10", "held while older present", iss_valid, 0);
        tick();
        chk("R10", "held while barrier at front", iss_valid, 0);
        tick();
        chk("R10", "released after barrier", iss_valid, 2'b01);
        chk("R10", "released slot", iss_slot[1:0], 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule